// File: doc/BRIEF.md
# Watchdog Timer with Pulsed Reset Output

This block is a free-running up-counter on the peripheral clock, compared every cycle against a programmable match value. In watchdog mode, software must service the counter before it reaches the match value. If it does not, the active-low match output drops and the counter expires. Two enable inputs then decide what the expiry does:

- Nothing beyond the match indication.
- A one-cycle internal chip reset request.
- A pulse of programmable length that drives both the active-low external reset pin and the internal reset request.

A sticky cause flag records that a watchdog reset took place. Only an explicit clear removes it.

With watchdog mode off, the same counter acts as a plain timer. It raises a one-cycle hit strobe at each match and keeps running. In both modes counting stops while the debug-halt input is high. A reload strobe returns the counter to zero.

Top module: `wdr_top`

## Requirements
- R1: `count` rises by exactly one per clock while `count_en` is 1 and `dbg_halt` is 0, and otherwise holds, unless a clear in R6 or R10 applies.
- R2: `match_n` is 0 exactly when `wd_mode` is 1 and `count` equals `match_val`, and is 1 otherwise; it is always 1 in timer mode.
- R3: An expiry is a cycle with `wd_mode`=1, `count_en`=1, `dbg_halt`=0, `reload`=0 and `count`=`match_val`. With `int_rst_en`=1 and `ext_rst_en`=0, `chip_rst` is 1 for exactly the one cycle after the expiry, and `ext_rst_n` stays 1.
- R4: On an expiry with `ext_rst_en`=1, whatever `int_rst_en` is, `ext_rst_n` is 0 and `chip_rst` is 1 for max(`pulse_len`,1) consecutive cycles, starting the cycle after the expiry.
- R5: On an expiry with both enables 0, `chip_rst` and `ext_rst_n` do not move, `rst_flag` keeps its value, and `count` restarts from zero.
- R6: After any expiry, `count` is zero in the next cycle. It stays zero while the external pulse is active, then counts again.
- R7: `rst_flag` becomes 1 in the same cycle `chip_rst` first rises for an expiry, and stays 1 until `flag_clr` is pulsed. When an expiry and `flag_clr` fall in the same cycle, the flag ends up 1.
- R8: In timer mode (`wd_mode`=0), a counting cycle with `count`=`match_val` makes `timer_hit` 1 for the next single cycle. The counter keeps running, and no reset output moves.
- R9: While `dbg_halt` is 1, `count` holds its value and neither an expiry nor a timer hit can occur.
- R10: A `reload` pulse makes `count` zero in the next cycle. A `reload` in the same cycle as a would-be expiry cancels that expiry: no reset and no flag.
- R11: After `rst_n` is released, `count`=0, `match_n`=1, `chip_rst`=0, `ext_rst_n`=1, `rst_flag`=0 and `timer_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| count_en | input | 1 | Counting enable |
| dbg_halt | input | 1 | Core-in-debug indication; pauses counting |
| wd_mode | input | 1 | 1 = watchdog mode, 0 = plain timer |
| int_rst_en | input | 1 | Enables the one-cycle internal reset on expiry |
| ext_rst_en | input | 1 | Enables the pulsed external and internal reset on expiry |
| match_val | input | 32 | Match value compared with the counter |
| pulse_len | input | 16 | External pulse length in cycles (0 acts as 1) |
| reload | input | 1 | Service strobe; zeroes the counter |
| flag_clr | input | 1 | Clears the reset-cause flag |
| count | output | 32 | Current counter value |
| match_n | output | 1 | Active-low match indication in watchdog mode |
| chip_rst | output | 1 | Internal chip reset request, active high |
| ext_rst_n | output | 1 | External reset pin, active low |
| rst_flag | output | 1 | Sticky watchdog-reset flag |
| timer_hit | output | 1 | One-cycle match strobe in timer mode |

## Verification
Two pairs of functions can fall in the same cycle.

- A service reload can arrive in the very cycle the counter sits on the match value. The bench steers the counter onto the match and pulses reload there. It expects no reset, an unset flag and a zero count one cycle later.
- A flag clear can coincide with an expiry. The bench times the clear onto the expiry cycle and expects the flag to read 1 once the reset begins.

Random runs mix both collisions with halts, mode switches and changing pulse lengths. A cycle-level reference model built from the requirements judges every output.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    // Action chosen for an expiry, from the two enable inputs.
    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_INTERNAL = 2'd1,
        ACT_PULSED   = 2'd2
    } wdr_act_e;

    function automatic wdr_act_e wdr_pick_action(input logic int_en, input logic ext_en);
        if (ext_en)      return ACT_PULSED;
        else if (int_en) return ACT_INTERNAL;
        else             return ACT_NONE;
    endfunction

endpackage

// File: rtl/wdr_counter.sv
module wdr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             clear,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             hit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.count = '0;
        end else if (advance) begin
            st_d.count = st_q.count + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
    assign hit   = (st_q.count == match_val);

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0)); // R10
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(count)); // R9

endmodule

// File: rtl/wdr_pulse.sv
module wdr_pulse #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             busy
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        logic [LEN_W-1:0] remain;
    } pls_state_t;

    pls_state_t st_d, st_q;
    logic [LEN_W-1:0] eff_len;

    always_comb begin
        eff_len = (len == '0) ? ONE : len;
        st_d    = st_q;
        if (start) begin
            st_d.remain = eff_len;
        end else if (st_q.remain != '0) begin
            st_d.remain = st_q.remain - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.remain != '0);

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R4
    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.remain == ONE && !start) |=> !busy); // R4

endmodule

// File: rtl/wdr_top.sv
module wdr_top
    import wdr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             dbg_halt,
    input  logic             wd_mode,
    input  logic             int_rst_en,
    input  logic             ext_rst_en,
    input  logic [CNT_W-1:0] match_val,
    input  logic [LEN_W-1:0] pulse_len,
    input  logic             reload,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             match_n,
    output logic             chip_rst,
    output logic             ext_rst_n,
    output logic             rst_flag,
    output logic             timer_hit
);

    typedef struct packed {
        logic int_pls;
        logic flag;
        logic thit;
    } top_state_t;

    top_state_t st_d, st_q;

    logic     hit, advance, expire, busy, cnt_clear, pls_start;
    wdr_act_e action;

    always_comb begin
        advance   = count_en && !dbg_halt;
        expire    = wd_mode && advance && hit && !reload;
        action    = wdr_pick_action(int_rst_en, ext_rst_en);
        pls_start = expire && (action == ACT_PULSED);
        cnt_clear = reload || expire || busy;

        st_d         = st_q;
        st_d.int_pls = expire && (action == ACT_INTERNAL);
        st_d.thit    = !wd_mode && advance && hit;
        if (expire && (action != ACT_NONE)) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    wdr_counter #(.CNT_W(CNT_W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .clear     (cnt_clear),
        .match_val (match_val),
        .count     (count),
        .hit       (hit)
    );

    wdr_pulse #(.LEN_W(LEN_W)) i_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pls_start),
        .len   (pulse_len),
        .busy  (busy)
    );

    assign match_n   = !(wd_mode && hit);
    assign chip_rst  = st_q.int_pls || busy;
    assign ext_rst_n = !busy;
    assign rst_flag  = st_q.flag;
    assign timer_hit = st_q.thit;

    AST_MATCH_ONLY_WD: assert property (@(posedge clk) disable iff (!rst_n)
        !match_n |-> wd_mode); // R2
    AST_EXPIRY_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && (int_rst_en || ext_rst_en)) |=> chip_rst); // R3
    AST_EXT_WITH_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rst_n |-> chip_rst); // R4
    AST_FLAG_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst) |-> rst_flag); // R7
    AST_PULSE_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (count == '0)); // R6
    AST_HIT_TIMER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        timer_hit |-> $past(!wd_mode)); // R8

endmodule

// File: tb/test_wdr_top.sv
module test_wdr_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        count_en, dbg_halt, wd_mode, int_rst_en, ext_rst_en;
    logic [31:0] match_val;
    logic [15:0] pulse_len;
    logic        reload, flag_clr;
    logic [31:0] count;
    logic        match_n, chip_rst, ext_rst_n, rst_flag, timer_hit;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // reference model state
    logic [31:0] m_count;
    logic [15:0] m_pcnt;
    logic        m_int, m_flag, m_thit;

    always #2 clk = ~clk;

    wdr_top i_wdr_top (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .dbg_halt(dbg_halt),
        .wd_mode(wd_mode), .int_rst_en(int_rst_en), .ext_rst_en(ext_rst_en),
        .match_val(match_val), .pulse_len(pulse_len), .reload(reload),
        .flag_clr(flag_clr), .count(count), .match_n(match_n),
        .chip_rst(chip_rst), .ext_rst_n(ext_rst_n), .rst_flag(rst_flag),
        .timer_hit(timer_hit)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_match_n();
        return !(wd_mode && (m_count == match_val));
    endfunction

    function automatic logic exp_chip();
        return m_int || (m_pcnt != 16'd0);
    endfunction

    // advance the model by one clock edge using the inputs now applied
    task automatic model_step();
        logic adv, hitv, busyv, fire;
        adv   = count_en && !dbg_halt;
        hitv  = (m_count == match_val);
        busyv = (m_pcnt != 16'd0);
        fire  = wd_mode && adv && hitv && !reload;
        if (reload || fire || busyv) m_count = 32'd0;
        else if (adv)                m_count = m_count + 32'd1;
        if (fire && ext_rst_en)      m_pcnt = (pulse_len == 16'd0) ? 16'd1 : pulse_len;
        else if (busyv)              m_pcnt = m_pcnt - 16'd1;
        m_int  = fire && int_rst_en && !ext_rst_en;
        if (fire && (int_rst_en || ext_rst_en)) m_flag = 1'b1;
        else if (flag_clr)                      m_flag = 1'b0;
        m_thit = !wd_mode && adv && hitv;
    endtask

    task automatic compare_all();
        chk("R1", "count",     count,     m_count);
        chk("R2", "match_n",   match_n,   exp_match_n());
        chk("R3", "chip_rst",  chip_rst,  exp_chip());
        chk("R4", "ext_rst_n", ext_rst_n, m_pcnt == 16'd0);
        chk("R7", "rst_flag",  rst_flag,  m_flag);
        chk("R8", "timer_hit", timer_hit, m_thit);
    endtask

    // inputs are applied at a falling edge; this crosses one rising edge and checks
    task automatic tick();
        model_step();
        @(negedge clk);
        compare_all();
        reload   = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic run_to(input logic [31:0] val);
        for (int i = 0; i < 200 && m_count != val; i++) tick();
    endtask

    initial begin
        void'($urandom(32'd5173));
        rst_n = 1'b0; count_en = 1'b0; dbg_halt = 1'b0; wd_mode = 1'b1;
        int_rst_en = 1'b0; ext_rst_en = 1'b0; match_val = 32'd6; pulse_len = 16'd3;
        reload = 1'b0; flag_clr = 1'b0;
        m_count = 0; m_pcnt = 0; m_int = 0; m_flag = 0; m_thit = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "count",     count,     32'd0);
        chk("R11", "match_n",   match_n,   1'b1);
        chk("R11", "chip_rst",  chip_rst,  1'b0);
        chk("R11", "ext_rst_n", ext_rst_n, 1'b1);
        chk("R11", "rst_flag",  rst_flag,  1'b0);
        chk("R11", "timer_hit", timer_hit, 1'b0);

        // R5: expiry with both enables off
        count_en = 1'b1;
        run_to(32'd6);
        chk("R2", "match_n at match", match_n, 1'b0);
        tick();
        chk("R5", "count restart", count, 32'd0);
        chk("R5", "chip_rst idle", chip_rst, 1'b0);
        chk("R5", "flag untouched", rst_flag, 1'b0);

        // R3: internal-only reset for one cycle
        int_rst_en = 1'b1;
        run_to(32'd6);
        tick();
        chk("R3", "chip_rst pulse", chip_rst, 1'b1);
        chk("R3", "ext pin idle", ext_rst_n, 1'b1);
        chk("R7", "flag set", rst_flag, 1'b1);
        tick();
        chk("R3", "chip_rst one cycle", chip_rst, 1'b0);

        // R7: clear, then collision of clear with expiry
        flag_clr = 1'b1; tick();
        chk("R7", "flag cleared", rst_flag, 1'b0);
        int_rst_en = 1'b0; ext_rst_en = 1'b1; pulse_len = 16'd4;
        run_to(32'd6);
        flag_clr = 1'b1;
        tick();
        chk("R7", "set wins over clear", rst_flag, 1'b1);
        // R4/R6: pulse of 4 cycles, counter held
        for (int i = 1; i < 4; i++) begin
            chk("R4", "ext low in pulse", ext_rst_n, 1'b0);
            chk("R6", "count held", count, 32'd0);
            tick();
        end
        chk("R4", "ext low last", ext_rst_n, 1'b0);
        tick();
        chk("R4", "ext released", ext_rst_n, 1'b1);
        chk("R6", "count still zero", count, 32'd0);
        tick();
        chk("R6", "count resumes", count, 32'd1);

        // R4: zero length acts as one cycle
        pulse_len = 16'd0;
        run_to(32'd6);
        tick();
        chk("R4", "zero len pulse", ext_rst_n, 1'b0);
        tick();
        chk("R4", "zero len ends", ext_rst_n, 1'b1);

        // R10: reload colliding with match
        flag_clr = 1'b1; tick();
        run_to(32'd6);
        reload = 1'b1;
        tick();
        chk("R10", "count zero", count, 32'd0);
        chk("R10", "no reset", chip_rst, 1'b0);
        chk("R10", "no flag", rst_flag, 1'b0);

        // R9: debug halt freezes and blocks expiry
        run_to(32'd6);
        dbg_halt = 1'b1;
        repeat (4) tick();
        chk("R9", "frozen count", count, 32'd6);
        chk("R9", "no expiry", chip_rst, 1'b0);
        dbg_halt = 1'b0;
        tick();
        chk("R9", "expires after halt", chip_rst, 1'b1);
        repeat (2) tick();

        // R8: timer mode
        wd_mode = 1'b0; reload = 1'b1; tick();
        run_to(32'd6);
        chk("R2", "match_n high in timer", match_n, 1'b1);
        tick();
        chk("R8", "timer_hit", timer_hit, 1'b1);
        chk("R8", "keeps running", count, 32'd7);
        chk("R8", "no reset", chip_rst, 1'b0);
        tick();
        chk("R8", "hit one cycle", timer_hit, 1'b0);

        // R1: count_en low holds
        count_en = 1'b0; repeat (3) tick();
        chk("R1", "hold when disabled", count, 32'd8);
        count_en = 1'b1;

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 63) == 0) wd_mode = ~wd_mode;
            if ($urandom_range(0, 31) == 0) begin
                int_rst_en = 1'($urandom_range(0, 1));
                ext_rst_en = 1'($urandom_range(0, 1));
                match_val  = 32'($urandom_range(1, 24));
                pulse_len  = 16'($urandom_range(0, 6));
            end
            count_en = ($urandom_range(0, 9) != 0);
            dbg_halt = ($urandom_range(0, 11) == 0);
            reload   = ($urandom_range(0, 19) == 0) ||
                       (m_count == match_val && $urandom_range(0, 3) == 0);
            flag_clr = ($urandom_range(0, 15) == 0) ||
                       (m_count == match_val && $urandom_range(0, 3) == 0);
            tick();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule